// File: doc/BRIEF.md
# Counter-Mode Cipher Block Sequencer

This unit sits between a host command port and an external cipher core. The host programs a source/destination base address, a byte length, a 128-bit initial counter, two 128-bit keys and a key-select bit through byte-wide register reads and writes inside a 64-byte window at host addresses 0xFF00 to 0xFF3F. Writing the start value launches a job.

A job runs block by block. The unit fetches sixteen bytes one at a time from a synchronous byte-wide memory. It presents the assembled block, the counter for that block and the selected key to the cipher core, and waits for the core's done pulse. It then writes the sixteen result bytes back to the addresses they came from. A block offset advances by 16 after each block until the length is covered. While a job runs, every register stays readable, but host writes are ignored.

Top module: `cipher_stream_seq`

## Requirements
- R1: After reset the state is idle (0), the read-data output is 0, and no memory access or cipher request is active.
- R2: A command with code 1 whose address lies in 0xFF00..0xFF3F loads the read-data output at the next clock edge with the addressed byte. The window offsets are:
  - 0x00: state, zero-extended.
  - 0x01: key select in bit 0.
  - 0x02..0x03: base address.
  - 0x04..0x05: length.
  - 0x10..0x1F: counter.
  - 0x20..0x2F: key 0.
  - 0x30..0x3F: key 1.
  
  Every multi-byte register is little-endian, so its lowest offset holds its least significant byte.
- R3: A read of an unmapped offset, or of any address outside the window, returns 0. Command codes 0 and 3 change neither a register nor the read-data output.
- R4: A command with code 2 writes the addressed register byte only while the state is idle. Writes issued while a job runs leave every register unchanged.
- R5: Writing the value 0x01 to offset 0x00 while idle moves the state to 1 (fetch) and clears the block offset, block index and processed count. Any other value written to offset 0x00 starts nothing.
- R6: In fetch, byte i (0..15) of the block is read from address base + block offset + i, in ascending order. It lands in bits [8i+7:8i] of the block.
- R7: In state 2 the cipher request stays high until done. The request carries the block, the selected key (key 0 when key select is 0, else key 1) and the counter plus the block index, where the block index is 0 for the first block of the job.
- R8: In state 3, byte i of the cipher result is written to address base + block offset + i. The first write follows the cycle in which done was seen.
- R9: After each block the processed count grows by 16. If the new count is below the length, the offset grows by 16 and the unit returns to fetch; otherwise it returns to idle. A length of 16 or less therefore processes exactly one block, and bytes past the last processed block are untouched.
- R10: At most one memory access (read or write) is issued per cycle, and none while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 2 | 1 = register read, 2 = register write, others no-op |
| cmd_addr | input | 16 | Host register address |
| cmd_wdata | input | 8 | Host write byte |
| rd_data | output | 8 | Registered read result |
| mem_rd_en | output | 1 | Memory read strobe, data valid one cycle later |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| cph_req | output | 1 | Cipher request, held until done |
| cph_ctr | output | 128 | Counter value for this block |
| cph_key | output | 128 | Selected key |
| cph_blk | output | 128 | Data block |
| cph_done | input | 1 | Cipher completion pulse |
| cph_result | input | 128 | Cipher output, valid with done |

## Verification
The hardest situations to reach from the ports are the block-loop decisions and the write lock, because both depend on internal counters that the host cannot see. The bench chooses lengths that land below, exactly on and far under a 16-byte boundary. It then checks the memory byte just past the last expected block. A bench-side cipher model mixes the counter and the key into every result byte, so a wrong block index or a wrong key shows up in memory. A length write issued while the job is still fetching, followed by a read-back, exposes any write that leaks through the lock.

// File: rtl/cipher_stream_seq.sv
module cipher_stream_seq #(
  parameter logic [15:0] WIN_BASE = 16'hFF00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cmd_code,
  input  logic [15:0]  cmd_addr,
  input  logic [7:0]   cmd_wdata,
  output logic [7:0]   rd_data,
  output logic         mem_rd_en,
  output logic         mem_wr_en,
  output logic [15:0]  mem_addr,
  output logic [7:0]   mem_wdata,
  input  logic [7:0]   mem_rdata,
  output logic         cph_req,
  output logic [127:0] cph_ctr,
  output logic [127:0] cph_key,
  output logic [127:0] cph_blk,
  input  logic         cph_done,
  input  logic [127:0] cph_result
);
  localparam logic [1:0] S_IDLE = 2'd0, S_FETCH = 2'd1, S_CIPH = 2'd2, S_PUT = 2'd3;
  localparam logic [1:0] C_RD = 2'd1, C_WR = 2'd2;

  logic [1:0]   st;
  logic [15:0]  base_q, len_q, off_q, cnt_q, bnum_q;
  logic         ksel_q;
  logic [127:0] ctr_q, key0_q, key1_q, blk_q;
  logic [3:0]   idx_q, ridx_q;
  logic         all_issued, rv_q;

  logic         in_win, wr_ok;
  logic [5:0]   woff;
  logic [7:0]   rd_mux;
  logic [16:0]  next_cnt;

  assign woff     = cmd_addr[5:0];
  assign in_win   = cmd_addr[15:6] == WIN_BASE[15:6];
  assign wr_ok    = cmd_code == C_WR && in_win && st == S_IDLE;
  assign next_cnt = {1'b0, cnt_q} + 17'd16;

  assign mem_addr  = base_q + off_q + {12'd0, idx_q};
  assign mem_rd_en = st == S_FETCH && !all_issued;
  assign mem_wr_en = st == S_PUT;
  assign mem_wdata = blk_q[idx_q*8 +: 8];
  assign cph_req   = st == S_CIPH;
  assign cph_ctr   = ctr_q + {112'd0, bnum_q};
  assign cph_key   = ksel_q ? key1_q : key0_q;
  assign cph_blk   = blk_q;

  always_comb begin
    rd_mux = 8'h00;
    case (woff[5:4])
      2'd0: begin
        case (woff[3:0])
          4'h0: rd_mux = {6'd0, st};
          4'h1: rd_mux = {7'd0, ksel_q};
          4'h2: rd_mux = base_q[7:0];
          4'h3: rd_mux = base_q[15:8];
          4'h4: rd_mux = len_q[7:0];
          4'h5: rd_mux = len_q[15:8];
          default: rd_mux = 8'h00;
        endcase
      end
      2'd1: rd_mux = ctr_q[woff[3:0]*8 +: 8];
      2'd2: rd_mux = key0_q[woff[3:0]*8 +: 8];
      default: rd_mux = key1_q[woff[3:0]*8 +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
    end else if (cmd_code == C_RD) begin
      rd_data <= in_win ? rd_mux : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; len_q <= '0; ksel_q <= 1'b0;
      ctr_q <= '0; key0_q <= '0; key1_q <= '0;
    end else if (wr_ok) begin
      case (woff[5:4])
        2'd0: begin
          case (woff[3:0])
            4'h1: ksel_q <= cmd_wdata[0];
            4'h2: base_q[7:0] <= cmd_wdata;
            4'h3: base_q[15:8] <= cmd_wdata;
            4'h4: len_q[7:0] <= cmd_wdata;
            4'h5: len_q[15:8] <= cmd_wdata;
            default: ;
          endcase
        end
        2'd1: ctr_q[woff[3:0]*8 +: 8] <= cmd_wdata;
        2'd2: key0_q[woff[3:0]*8 +: 8] <= cmd_wdata;
        default: key1_q[woff[3:0]*8 +: 8] <= cmd_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; off_q <= '0; cnt_q <= '0; bnum_q <= '0;
      idx_q <= '0; ridx_q <= '0; all_issued <= 1'b0; rv_q <= 1'b0;
      blk_q <= '0;
    end else begin
      rv_q   <= mem_rd_en;
      ridx_q <= idx_q;
      case (st)
        S_IDLE: begin
          if (wr_ok && woff == 6'h00 && cmd_wdata == 8'h01) begin
            st <= S_FETCH; off_q <= '0; cnt_q <= '0; bnum_q <= '0;
            idx_q <= '0; all_issued <= 1'b0;
          end
        end
        S_FETCH: begin
          if (mem_rd_en) begin
            if (idx_q == 4'hF) all_issued <= 1'b1;
            else idx_q <= idx_q + 4'd1;
          end
          if (rv_q) begin
            blk_q[ridx_q*8 +: 8] <= mem_rdata;
            if (ridx_q == 4'hF) begin
              st <= S_CIPH; idx_q <= '0; all_issued <= 1'b0;
            end
          end
        end
        S_CIPH: begin
          if (cph_done) begin
            blk_q <= cph_result;
            st <= S_PUT;
            idx_q <= '0;
          end
        end
        default: begin
          idx_q <= idx_q + 4'd1;
          if (idx_q == 4'hF) begin
            cnt_q <= next_cnt[15:0];
            if (next_cnt < {1'b0, len_q}) begin
              off_q <= off_q + 16'd16;
              bnum_q <= bnum_q + 16'd1;
              st <= S_FETCH;
            end else begin
              st <= S_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

module cipher_stream_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  st,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic        cph_req,
  input logic        cph_done,
  input logic [15:0] len_q,
  input logic [15:0] base_q,
  input logic        ksel_q
);
  // R10
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (!mem_rd_en && !mem_wr_en && !cph_req));
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cph_req && !cph_done) |=> cph_req);
  // R4
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |=> ($stable(len_q) && $stable(base_q) && $stable(ksel_q)));
  // R8
  put_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_en) |-> $past(cph_done));
  // R5
  start_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |=> (st == 2'd0 || st == 2'd1));
endmodule

bind cipher_stream_seq cipher_stream_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .cph_req(cph_req), .cph_done(cph_done),
  .len_q(len_q), .base_q(base_q), .ksel_q(ksel_q)
);

// File: tb/cipher_stream_seq_bench.sv
`timescale 1ns/1ps
module cipher_stream_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic [15:0] cmd_addr = 16'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic [7:0] rd_data;
  logic mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic cph_req;
  logic [127:0] cph_ctr, cph_key, cph_blk;
  logic cph_done;
  logic [127:0] cph_result;

  int tests = 0, fails = 0, overlap = 0;
  bit finished = 0;

  logic [7:0] mem [0:65535];
  logic [7:0] shadow [0:65535];
  logic [2:0] dly;

  always #5 clk = ~clk;

  cipher_stream_seq u_cipher_stream_seq (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rd_data(rd_data), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cph_req(cph_req), .cph_ctr(cph_ctr),
    .cph_key(cph_key), .cph_blk(cph_blk), .cph_done(cph_done),
    .cph_result(cph_result));

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      dly <= 3'd0; cph_done <= 1'b0; cph_result <= '0;
    end else begin
      cph_done <= 1'b0;
      if (cph_req && !cph_done) begin
        if (dly == 3'd3) begin
          cph_done <= 1'b1;
          cph_result <= cph_blk ^ cph_ctr ^ cph_key;
          dly <= 3'd0;
        end else dly <= dly + 3'd1;
      end else dly <= 3'd0;
    end
  end

  always @(negedge clk) if (rst_n && mem_rd_en && mem_wr_en) overlap++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cmd_code = 2'd2; cmd_addr = a; cmd_wdata = d;
    @(negedge clk); cmd_code = 2'd0;
  endtask

  task automatic hr(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); cmd_code = 2'd1; cmd_addr = a;
    @(negedge clk); d = rd_data; cmd_code = 2'd0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int n = 0; n < 3000; n++) begin
      hr(16'hFF00, s);
      if (s == 8'd0) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(rd_data == 8'd0, "R1 rd_data", {24'd0, rd_data}, 0);
    check(!mem_rd_en && !mem_wr_en && !cph_req, "R1 idle outputs",
          {29'd0, mem_rd_en, mem_wr_en, cph_req}, 0);
    hr(16'hFF00, d);
    check(d == 8'd0, "R1 state", {24'd0, d}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    hw(16'hFF02, 8'h34); hw(16'hFF03, 8'h12);
    hw(16'hFF04, 8'hCD); hw(16'hFF05, 8'hAB);
    hw(16'hFF01, 8'hFF);
    hw(16'hFF17, 8'h5A); hw(16'hFF20, 8'hC3); hw(16'hFF3F, 8'h99);
    hr(16'hFF02, d); check(d == 8'h34, "R2 base low byte", {24'd0, d}, 32'h34);
    hr(16'hFF03, d); check(d == 8'h12, "R2 base high byte", {24'd0, d}, 32'h12);
    hr(16'hFF05, d); check(d == 8'hAB, "R2 length high byte", {24'd0, d}, 32'hAB);
    hr(16'hFF01, d); check(d == 8'h01, "R2 key select zero-extended", {24'd0, d}, 1);
    hr(16'hFF17, d); check(d == 8'h5A, "R2 counter byte 7", {24'd0, d}, 32'h5A);
    hr(16'hFF20, d); check(d == 8'hC3, "R2 key0 byte 0", {24'd0, d}, 32'hC3);
    hr(16'hFF3F, d); check(d == 8'h99, "R2 key1 byte 15", {24'd0, d}, 32'h99);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    hr(16'hFF08, d); check(d == 8'h00, "R3 unmapped offset", {24'd0, d}, 0);
    hr(16'hFF02, d);
    hr(16'h1234, d); check(d == 8'h00, "R3 outside window", {24'd0, d}, 0);
    hr(16'hFF02, d);
    @(negedge clk); cmd_code = 2'd3; cmd_addr = 16'hFF02; cmd_wdata = 8'hEE;
    @(negedge clk); cmd_code = 2'd0; cmd_addr = 16'hFF05;
    @(negedge clk);
    check(rd_data == 8'h34, "R3 no-op code keeps rd_data", {24'd0, rd_data}, 32'h34);
    hr(16'hFF02, d); check(d == 8'h34, "R3 no-op code keeps register", {24'd0, d}, 32'h34);
  endtask

  task automatic t_bad_start();
    logic [7:0] d;
    hw(16'hFF00, 8'h02);
    hr(16'hFF00, d); check(d == 8'h00, "R5 non-start value ignored", {24'd0, d}, 0);
  endtask

  task automatic run_job(input logic [15:0] base, input logic [15:0] len,
                         input logic [127:0] ctr, input logic [127:0] k0,
                         input logic [127:0] k1, input bit ksel, input string tag);
    logic [7:0] d;
    int nblk, bad;
    logic [127:0] cb, key;
    hw(16'hFF02, base[7:0]); hw(16'hFF03, base[15:8]);
    hw(16'hFF04, len[7:0]);  hw(16'hFF05, len[15:8]);
    hw(16'hFF01, {7'd0, ksel});
    for (int i = 0; i < 16; i++) begin
      hw(16'hFF10 + 16'(i), ctr[i*8 +: 8]);
      hw(16'hFF20 + 16'(i), k0[i*8 +: 8]);
      hw(16'hFF30 + 16'(i), k1[i*8 +: 8]);
    end
    hw(16'hFF00, 8'h01);
    hr(16'hFF00, d);
    check(d == 8'h01, {"R5 state fetch after start ", tag}, {24'd0, d}, 1);
    hw(16'hFF04, 8'hFF);
    hr(16'hFF04, d);
    check(d == len[7:0], {"R4 busy write ignored ", tag}, {24'd0, d}, {24'd0, len[7:0]});
    wait_idle();
    nblk = (len <= 16) ? 1 : (int'(len) + 15) / 16;
    key = ksel ? k1 : k0;
    bad = 0;
    for (int b = 0; b < nblk; b++) begin
      cb = ctr + 128'(b);
      for (int i = 0; i < 16; i++) begin
        logic [15:0] a;
        logic [7:0] e;
        a = base + 16'(b * 16 + i);
        e = shadow[a] ^ cb[i*8 +: 8] ^ key[i*8 +: 8];
        if (mem[a] !== e) begin
          if (bad == 0)
            check(0, {"R6 R7 R8 block data ", tag}, {24'd0, mem[a]}, {24'd0, e});
          bad++;
        end
        shadow[a] = e;
      end
    end
    if (bad == 0) check(1, {"R6 R7 R8 block data ", tag}, 0, 0);
    check(mem[base + 16'(nblk * 16)] == shadow[base + 16'(nblk * 16)],
          {"R9 byte past last block untouched ", tag},
          {24'd0, mem[base + 16'(nblk * 16)]}, {24'd0, shadow[base + 16'(nblk * 16)]});
    check(mem[base - 16'd1] == shadow[base - 16'd1], {"R8 byte before base untouched ", tag},
          {24'd0, mem[base - 16'd1]}, {24'd0, shadow[base - 16'd1]});
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regs();
    t_unmapped();
    t_bad_start();
    run_job(16'h0100, 16'd16, 128'h0102030405060708090A0B0C0D0E0F10,
            {4{32'hA5A55A5A}}, {4{32'h3C3CC3C3}}, 1'b0, "one block key0");
    run_job(16'h0200, 16'd40, 128'h000000000000000000000000FFFFFFFE,
            {4{32'h11223344}}, {4{32'hDEADBEEF}}, 1'b1, "three blocks key1");
    run_job(16'h0300, 16'd32, {4{32'h76543210}},
            {4{32'h0F0F0F0F}}, {4{32'hF0F0F0F0}}, 1'b0, "exact two blocks");
    run_job(16'h0400, 16'd0, {4{32'h13579BDF}},
            {4{32'h2468ACE0}}, {4{32'h55AA55AA}}, 1'b1, "zero length");
    check(overlap == 0, "R10 single memory access per cycle", overlap, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule